// File: doc/BRIEF.md
# 100BASE-X Receive Code-Group to MII Decoder

This block sits between code-group alignment and the MAC on the receive side of a 100 Mb/s PHY. On every receive clock it takes one aligned 5-bit code group. It emits the MII receive signals from that stream: a data-valid strobe, a 4-bit nibble and an error strobe. A frame opens when the start delimiter pair (J then K) is seen. That pair comes out as two preamble nibbles with data valid already high. After that, each data code group is translated to its nibble.

Inside a frame, a code group that is neither data nor part of a proper end pair is flagged on the error strobe for exactly one cycle. The nibble in that cycle is forced to a fixed value. A frame closes cleanly on the end delimiter pair (T then R). An idle group that arrives before that pair closes it with a premature-end error. Frame check sequence validation is left to the MAC.

The decoder looks one code group ahead. A group sampled at clock edge k is reported on the outputs after edge k+1.

Top module: `mii_rx_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs are `rx_dv`=0, `rxd`=0000 and `rx_er`=0, and the decoder returns to the out-of-frame state.
- R2: Out of frame, a J group (11000) directly followed by a K group (10001) starts a frame. The cycles reporting J and K each show `rx_dv`=1, `rxd`=0101 and `rx_er`=0. Each group sampled at edge k is reported after edge k+1.
- R3: In frame, data groups map to nibbles as follows (code:nibble): 11110:0, 01001:1, 10100:2, 10101:3, 01010:4, 01011:5, 01110:6, 01111:7, 10010:8, 10011:9, 10110:A, 10111:B, 11010:C, 11011:D, 11100:E, 11101:F. Each is shown with `rx_dv`=1 and `rx_er`=0.
- R4: In frame, a T group (01101) directly followed by an R group (00111) ends the frame. The cycle that would report T already shows `rx_dv`=0 and `rx_er`=0.
- R5: In frame, any group other than a data group, idle, or a T that is followed by R (this includes J, K, a lone T or R, and unassigned codes such as 00000) gives one cycle of `rx_er`=1, `rx_dv`=1 and `rxd`=0000. Consecutive such groups give one error cycle each.
- R6: In frame, an idle group (11111) ends the frame at once. Its cycle shows `rx_dv`=0, `rx_er`=1 and `rxd`=0000, and the following cycles are out of frame.
- R7: Out of frame, `rx_dv`, `rx_er` and `rxd` stay 0. A J not directly followed by K, and any other group, is ignored.
- R8: `rx_er` is high with `rx_dv` low only in the single cycle right after an in-frame cycle (the R6 case).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; all outputs change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cg | input | CG_W (5) | Aligned, descrambled code group, one per clock |
| rx_dv | output | 1 | Receive data valid |
| rxd | output | NIB_W (4) | Receive nibble |
| rx_er | output | 1 | Receive error strobe |

## Verification
The checker watches some rules on every cycle. A frame start after J/K must carry two 0101 nibbles. The nibble must be zero whenever data valid is low, and also during an in-frame error. An error strobe without data valid may only follow an in-frame cycle. The exact nibble for each data code, the one-error-per-bad-group count, and the choice between a clean T/R end and a premature idle end depend on the input history. Only the bench's directed frames, compared against its reference model, show those. The same holds for ignoring false starts and recovering from a reset in mid-frame.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

   localparam int CG_BITS  = 5;
   localparam int NIB_BITS = 4;
   localparam int N_DATA   = 16;

   localparam logic [CG_BITS-1:0] CG_J = 5'b11000;
   localparam logic [CG_BITS-1:0] CG_K = 5'b10001;
   localparam logic [CG_BITS-1:0] CG_T = 5'b01101;
   localparam logic [CG_BITS-1:0] CG_R = 5'b00111;
   localparam logic [CG_BITS-1:0] CG_I = 5'b11111;

   localparam logic [NIB_BITS-1:0] PRE_NIB = 4'b0101;

   // code group for nibble value n sits at index n
   localparam logic [CG_BITS-1:0] DATA_CG [N_DATA] = '{
      5'b11110, 5'b01001, 5'b10100, 5'b10101,
      5'b01010, 5'b01011, 5'b01110, 5'b01111,
      5'b10010, 5'b10011, 5'b10110, 5'b10111,
      5'b11010, 5'b11011, 5'b11100, 5'b11101};

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PRE   = 2'd1,
      ST_FRAME = 2'd2
   } rx_state_e;

   typedef struct packed {
      logic                is_data;
      logic [NIB_BITS-1:0] nib;
      logic                is_j;
      logic                is_k;
      logic                is_t;
      logic                is_r;
      logic                is_i;
   } cg_class_t;

   function automatic cg_class_t classify(input logic [CG_BITS-1:0] g);
      cg_class_t c;
      c      = '0;
      c.is_j = (g == CG_J);
      c.is_k = (g == CG_K);
      c.is_t = (g == CG_T);
      c.is_r = (g == CG_R);
      c.is_i = (g == CG_I);
      for (int n = 0; n < N_DATA; n++) begin
         if (g == DATA_CG[n]) begin
            c.is_data = 1'b1;
            c.nib     = NIB_BITS'(n);
         end
      end
      return c;
   endfunction

endpackage

// File: rtl/mii_cg_classify.sv
module mii_cg_classify
   import mii_rx_pkg::*;
#(
   parameter int CG_W = CG_BITS
) (
   input  logic [CG_W-1:0] cg,
   output cg_class_t       cls
);

   always_comb begin
      cls = classify(cg);
   end

endmodule

// File: rtl/mii_rx_fsm.sv
module mii_rx_fsm
   import mii_rx_pkg::*;
#(
   parameter int               CG_W          = CG_BITS,
   parameter int               NIB_W         = NIB_BITS,
   parameter bit               PREMATURE_ERR = 1'b1,
   parameter logic [NIB_W-1:0] ERR_NIB       = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cg_class_t        hold_c,
   input  logic [CG_W-1:0]  cur_cg,
   output logic             rx_dv,
   output logic [NIB_W-1:0] rxd,
   output logic             rx_er
);

   rx_state_e        st_q, st_d;
   logic             dv_d, er_d, prem_er, stray;
   logic [NIB_W-1:0] nib_d;

   // variant: flag a frame cut short by idle, or drop it silently
   generate
      if (PREMATURE_ERR) begin : g_prem_on
         assign prem_er = 1'b1;
      end else begin : g_prem_off
         assign prem_er = 1'b0;
      end
   endgenerate

   assign stray = hold_c.is_j | hold_c.is_k | hold_c.is_t | hold_c.is_r;

   always_comb begin
      st_d  = st_q;
      dv_d  = 1'b0;
      er_d  = 1'b0;
      nib_d = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (hold_c.is_j && (cur_cg == CG_K)) begin
               st_d  = ST_PRE;
               dv_d  = 1'b1;
               nib_d = PRE_NIB;
            end
         end
         ST_PRE: begin
            st_d  = ST_FRAME;
            dv_d  = 1'b1;
            nib_d = PRE_NIB;
         end
         ST_FRAME: begin
            if (hold_c.is_t && (cur_cg == CG_R)) begin
               st_d = ST_IDLE;
            end else if (hold_c.is_i) begin
               st_d = ST_IDLE;
               er_d = prem_er;
            end else if (hold_c.is_data && !stray) begin
               dv_d  = 1'b1;
               nib_d = hold_c.nib;
            end else begin
               dv_d  = 1'b1;
               er_d  = 1'b1;
               nib_d = ERR_NIB;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         rx_dv <= 1'b0;
         rx_er <= 1'b0;
         rxd   <= '0;
      end else begin
         st_q  <= st_d;
         rx_dv <= dv_d;
         rx_er <= er_d;
         rxd   <= nib_d;
      end
   end

endmodule

// File: rtl/mii_rx_decoder.sv
module mii_rx_decoder
   import mii_rx_pkg::*;
#(
   parameter int               CG_W          = 5,
   parameter int               NIB_W         = 4,
   parameter bit               PREMATURE_ERR = 1'b1,
   parameter logic [NIB_W-1:0] ERR_NIB       = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CG_W-1:0]  cg,
   output logic             rx_dv,
   output logic [NIB_W-1:0] rxd,
   output logic             rx_er
);

   generate
      if (CG_W != CG_BITS) begin : g_bad_cg
         $error("mii_rx_decoder: CG_W must be %0d", CG_BITS);
      end
      if (NIB_W != NIB_BITS) begin : g_bad_nib
         $error("mii_rx_decoder: NIB_W must be %0d", NIB_BITS);
      end
   endgenerate

   logic [CG_W-1:0] hold_q;
   cg_class_t       hold_c;

   // one-group lookahead: hold_q is reported while cg is peeked at
   always_ff @(posedge clk) begin
      if (!rst_n) hold_q <= CG_I;
      else        hold_q <= cg;
   end

   mii_cg_classify #(.CG_W(CG_W)) u_classify (
      .cg  (hold_q),
      .cls (hold_c)
   );

   mii_rx_fsm #(
      .CG_W          (CG_W),
      .NIB_W         (NIB_W),
      .PREMATURE_ERR (PREMATURE_ERR),
      .ERR_NIB       (ERR_NIB)
   ) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_c (hold_c),
      .cur_cg (cg),
      .rx_dv  (rx_dv),
      .rxd    (rxd),
      .rx_er  (rx_er)
   );

endmodule

// File: rtl/mii_rx_decoder_chk.sv
module mii_rx_decoder_chk
   import mii_rx_pkg::*;
#(
   parameter int CG_W  = 5,
   parameter int NIB_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CG_W-1:0]  cg,
   input logic             rx_dv,
   input logic [NIB_W-1:0] rxd,
   input logic             rx_er
);

   logic [1:0] age_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              age_q <= '0;
      else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
   end

   // R2
   jk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2 && $past(cg, 2) == CG_J && $past(cg) == CG_K && !$past(rx_dv))
      |-> (rx_dv && rxd == PRE_NIB && !rx_er));

   // R2
   pre_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_dv) |=> (rx_dv && rxd == PRE_NIB));

   // R5
   err_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_er && rx_dv) |-> (rxd == '0));

   // R7
   idle_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_dv |-> (rxd == '0));

   // R8
   lone_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_er && !rx_dv) |-> $past(rx_dv));

endmodule

bind mii_rx_decoder mii_rx_decoder_chk #(.CG_W(CG_W), .NIB_W(NIB_W)) i_chk (.*);

// File: tb/test_mii_rx_decoder.sv
module test_mii_rx_decoder;

   localparam time CLK_P = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] cg = 5'b11111;
   logic       rx_dv;
   logic [3:0] rxd;
   logic       rx_er;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   mii_rx_decoder i_mii_rx_decoder (
      .clk   (clk),
      .rst_n (rst_n),
      .cg    (cg),
      .rx_dv (rx_dv),
      .rxd   (rxd),
      .rx_er (rx_er)
   );

   // code tables written from the requirements
   logic [4:0] code_of [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                                5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
   localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                          R = 5'b00111, I = 5'b11111;

   function automatic int lookup(input logic [4:0] g);
      int v;
      v = -1;
      for (int n = 0; n < 16; n++) if (code_of[n] == g) v = n;
      return v;
   endfunction

   // behavioural reference: mode 0 out of frame, 1 second preamble, 2 in frame
   int         m_mode = 0;
   logic [4:0] m_prev = 5'b11111;
   logic       e_dv = 1'b0, e_er = 1'b0;
   logic [3:0] e_rxd = 4'h0;
   string      e_tag = "R1";

   always @(posedge clk) begin
      int d;
      if (!rst_n) begin
         m_mode = 0; m_prev = I;
         e_dv = 0; e_rxd = 0; e_er = 0; e_tag = "R1";
      end else begin
         d = lookup(m_prev);
         if (m_mode == 0) begin
            if (m_prev == J && cg == K) begin
               e_dv = 1; e_rxd = 4'h5; e_er = 0; e_tag = "R2"; m_mode = 1;
            end else begin
               e_dv = 0; e_rxd = 0; e_er = 0; e_tag = "R7";
            end
         end else if (m_mode == 1) begin
            e_dv = 1; e_rxd = 4'h5; e_er = 0; e_tag = "R2"; m_mode = 2;
         end else if (m_prev == T && cg == R) begin
            e_dv = 0; e_rxd = 0; e_er = 0; e_tag = "R4"; m_mode = 0;
         end else if (m_prev == I) begin
            e_dv = 0; e_rxd = 0; e_er = 1; e_tag = "R6"; m_mode = 0;
         end else if (d >= 0) begin
            e_dv = 1; e_rxd = 4'(d); e_er = 0; e_tag = "R3";
         end else begin
            e_dv = 1; e_rxd = 0; e_er = 1; e_tag = "R5";
         end
         m_prev = cg;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      checks++;
      if (rx_dv !== e_dv || rxd !== e_rxd || rx_er !== e_er) begin
         errors++;
         $display("FAIL %s: dv/rxd/er = %b/%h/%b, expected %b/%h/%b",
                  e_tag, rx_dv, rxd, rx_er, e_dv, e_rxd, e_er);
      end
      // R8: an error without data valid must be the premature-end cycle
      if (rst_n && rx_er === 1'b1 && rx_dv === 1'b0) begin
         checks++;
         if (e_tag != "R6") begin
            errors++;
            $display("FAIL R8: dv/er = %b/%b, expected error only at premature end (%s)",
                     rx_dv, rx_er, e_tag);
         end
      end
   end

   task automatic send(input logic [4:0] g);
      @(negedge clk);
      cg = g;
   endtask

   task automatic idles(input int n);
      for (int i = 0; i < n; i++) send(I);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 20000);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      // R1 reset state
      rst_n = 1'b0;
      idles(4);
      @(negedge clk); rst_n = 1'b1;
      idles(4);
      // R2, R3, R4: full frame with every data code, clean end
      send(J); send(K);
      for (int n = 0; n < 16; n++) send(code_of[n]);
      send(T); send(R); idles(3);
      // R5: unassigned codes back to back, lone T, stray K
      send(J); send(K); send(code_of[5]); send(5'b00000); send(5'b00000);
      send(code_of[3]); send(T); send(code_of[1]); send(K); send(R);
      send(T); send(R); idles(3);
      // R6: idle before the end pair
      send(J); send(K); send(code_of[7]); send(code_of[8]); send(I); idles(3);
      // R7: false start and stray delimiters out of frame
      send(J); send(code_of[1]); send(T); send(R); send(K); send(J); send(J); idles(2);
      // R2: J J K still starts; empty frame then back-to-back frame
      send(J); send(J); send(K); send(T); send(R);
      send(J); send(K); send(code_of[10]); send(T); send(R); idles(3);
      // R1: reset in mid frame
      send(J); send(K); send(code_of[1]); send(code_of[2]);
      @(negedge clk); rst_n = 1'b0; cg = code_of[4];
      send(code_of[6]);
      @(negedge clk); rst_n = 1'b1; cg = code_of[9];
      idles(4);
      // R3 again after recovery
      send(J); send(K); send(code_of[15]); send(code_of[0]); send(T); send(R);
      idles(4);
      finish_run();
   end

endmodule